// File: doc/BRIEF.md
# Processor Wait-State Controller

This block sequences a core through the execution of a wait instruction. When the issue stage presents a wait, the controller stops any new instruction from issuing. It then tracks the instructions still in flight until the last of them has retired. Only then is the wait complete. At that point the controller stops instruction fetch, enters its waiting state and raises an indicator that an external power and reset controller may use to put the chip into low power.

A normal interrupt or a debug interrupt ends the waiting state. The controller releases the core in the same cycle that it accepts the interrupt. It supplies the return address to save, which is the address of the instruction after the wait. This is the wait's own address plus its length of 2 or 4 bytes.

An interrupt that arrives while the pipeline is still draining is kept pending. When the drain finishes, the core returns directly to normal execution without entering the waiting state. The core clock enable stays on outside the waiting state. While waiting, it follows the activity flag of the other bus masters.

Top module: `core_wait_ctl`

## Requirements
- R1: After reset the controller is running: `issue_hold`, `fetch_stop`, `waiting` and `wake` are 0 and `core_clk_en` is 1.
- R2: A `wait_req` sampled while running raises `issue_hold` from the next cycle, and `issue_vld` is ignored by the in-flight count while `issue_hold` is 1.
- R3: While `issue_hold` is 1 and any instruction is still in flight (issued via `issue_vld`, not yet retired via `retire_vld`), `fetch_stop` and `waiting` stay 0.
- R4: The cycle after the in-flight count reaches zero with no interrupt seen, `fetch_stop` and `waiting` are 1 and `issue_hold` stays 1.
- R5: In the waiting state, `retire_vld`, `issue_vld`, `wait_req` and `bus_other_active` do not end the wait; `fetch_stop` stays 1.
- R6: When `irq` is 1 in the waiting state, `waiting` drops to 0 and `wake` is 1 in that same cycle; from the next cycle `issue_hold` and `fetch_stop` are 0.
- R7: `resume_pc` equals the `wait_pc` captured with `wait_req` plus 4 when `wait_long` is 1 and plus 2 when it is 0, with bit 0 forced to 0.
- R8: An `irq` or `dbg_irq` seen during the drain, even for one cycle, is held pending. When the count reaches zero, `wake` pulses and the controller returns to running without ever raising `waiting` or `fetch_stop`.
- R9: `core_clk_en` is 1 whenever `fetch_stop` is 0; in the waiting state it equals `bus_other_active`.
- R10: `dbg_irq` alone wakes the controller from the waiting state exactly as `irq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction issues this cycle |
| retire_vld | input | 1 | An in-flight instruction retires this cycle |
| wait_req | input | 1 | A wait instruction is at issue this cycle |
| wait_pc | input | ADDR_W | Address of the wait instruction |
| wait_long | input | 1 | Wait encoding length: 1 = 4 bytes, 0 = 2 bytes |
| irq | input | 1 | Normal interrupt request |
| dbg_irq | input | 1 | Debug interrupt request |
| bus_other_active | input | 1 | Another bus master is active |
| issue_hold | output | 1 | Blocks new instruction issue |
| fetch_stop | output | 1 | Instruction fetch halted (waiting state) |
| waiting | output | 1 | Waiting indicator to the power/reset controller |
| wake | output | 1 | Wake accepted this cycle; save `resume_pc` |
| resume_pc | output | ADDR_W | Return address of the instruction after the wait |
| core_clk_en | output | 1 | Core clock enable |

## Verification
The bench checks that a wait with instructions still outstanding does not reach the waiting state early. A design that ignored the in-flight count would raise `fetch_stop` while work was still retiring. It pulses an interrupt for one cycle during the drain. A design without a pending latch would lose that interrupt and go to sleep. A design without the direct path would flash `waiting` for a cycle. It checks both instruction lengths and an odd-halfword address, so an adder that used the wrong length would save the wrong return address. It toggles bus activity and unrelated inputs while waiting, so a clock enable that ignored other masters, or a wake on the wrong input, shows up at the ports.

// File: rtl/core_wait_pkg.sv
package core_wait_pkg;
   typedef enum logic [1:0] {
      CW_RUN   = 2'd0,
      CW_DRAIN = 2'd1,
      CW_SLEEP = 2'd2
   } cw_state_e;
endpackage

// File: rtl/cwc_inflight_cnt.sv
module cwc_inflight_cnt #(
   parameter int MAX_INFL = 15,
   localparam int CW = $clog2(MAX_INFL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count,
   output logic          empty
);
   initial begin
      if (MAX_INFL < 1) $error("MAX_INFL must be at least 1");
   end

   logic up_ok, dn_ok;
   assign up_ok = inc && (count != CW'(MAX_INFL));
   assign dn_ok = dec && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({up_ok, dn_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign empty = (count == '0);
endmodule

// File: rtl/cwc_ret_addr.sv
module cwc_ret_addr #(
   parameter int ADDR_W     = 32,
   parameter bit HALF_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] pc,
   input  logic              long_insn,
   output logic [ADDR_W-1:0] ret_pc
);
   initial begin
      if (ADDR_W < 4) $error("ADDR_W must be at least 4");
   end

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] next_pc;

   assign step = long_insn ? ADDR_W'(4) : ADDR_W'(2);
   assign sum  = pc + step;

   generate
      if (HALF_ALIGN) begin : g_align
         assign next_pc = {sum[ADDR_W-1:1], 1'b0};
      end else begin : g_raw
         assign next_pc = sum;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ret_pc <= '0;
      else if (capture) ret_pc <= next_pc;
   end
endmodule

// File: rtl/cwc_fsm.sv
module cwc_fsm
   import core_wait_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wait_req,
   input  logic      drained,
   input  logic      wake_src,
   output cw_state_e state,
   output logic      pend,
   output logic      wake
);
   cw_state_e nxt;
   logic      pend_nxt;

   always_comb begin
      nxt      = state;
      pend_nxt = pend;
      wake     = 1'b0;
      case (state)
         CW_RUN: begin
            pend_nxt = 1'b0;
            if (wait_req) nxt = CW_DRAIN;
         end
         CW_DRAIN: begin
            pend_nxt = pend | wake_src;
            if (drained) begin
               if (pend || wake_src) begin
                  nxt  = CW_RUN;
                  wake = 1'b1;
               end else begin
                  nxt = CW_SLEEP;
               end
               pend_nxt = 1'b0;
            end
         end
         CW_SLEEP: begin
            if (wake_src) begin
               nxt  = CW_RUN;
               wake = 1'b1;
            end
         end
         default: nxt = CW_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CW_RUN;
         pend  <= 1'b0;
      end else begin
         state <= nxt;
         pend  <= pend_nxt;
      end
   end
endmodule

// File: rtl/core_wait_ctl.sv
module core_wait_ctl
   import core_wait_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int MAX_INFL   = 15,
   parameter bit HALF_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_vld,
   input  logic              retire_vld,
   input  logic              wait_req,
   input  logic [ADDR_W-1:0] wait_pc,
   input  logic              wait_long,
   input  logic              irq,
   input  logic              dbg_irq,
   input  logic              bus_other_active,
   output logic              issue_hold,
   output logic              fetch_stop,
   output logic              waiting,
   output logic              wake,
   output logic [ADDR_W-1:0] resume_pc,
   output logic              core_clk_en
);
   localparam int CW = $clog2(MAX_INFL + 1);

   cw_state_e         state;
   logic              pend;
   logic              drained;
   logic              wake_src;
   logic              in_run;
   logic [CW-1:0]     infl_cnt;

   assign wake_src = irq | dbg_irq;
   assign in_run   = (state == CW_RUN);

   cwc_inflight_cnt #(.MAX_INFL(MAX_INFL)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (issue_vld && in_run),
      .dec   (retire_vld),
      .count (infl_cnt),
      .empty (drained)
   );

   cwc_ret_addr #(.ADDR_W(ADDR_W), .HALF_ALIGN(HALF_ALIGN)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (wait_req && in_run),
      .pc        (wait_pc),
      .long_insn (wait_long),
      .ret_pc    (resume_pc)
   );

   cwc_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_req (wait_req),
      .drained  (drained),
      .wake_src (wake_src),
      .state    (state),
      .pend     (pend),
      .wake     (wake)
   );

   assign issue_hold  = !in_run;
   assign fetch_stop  = (state == CW_SLEEP);
   assign waiting     = fetch_stop && !wake_src;
   assign core_clk_en = !fetch_stop || bus_other_active;
endmodule

// File: rtl/core_wait_ctl_chk.sv
module core_wait_ctl_chk #(
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wait_req,
   input logic          irq,
   input logic          dbg_irq,
   input logic          issue_hold,
   input logic          fetch_stop,
   input logic          waiting,
   input logic          wake,
   input logic          core_clk_en,
   input logic [CW-1:0] infl_cnt
);
   a_r2_hold_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !issue_hold) |=> issue_hold);

   a_r3_busy_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_hold && !fetch_stop && infl_cnt != '0) |=> !fetch_stop);

   a_r4_stop_implies_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stop |-> issue_hold);

   a_r5_sleep_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stop && !irq && !dbg_irq) |=> fetch_stop);

   a_r6_wake_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stop && (irq || dbg_irq)) |-> (!waiting && wake));

   a_r6_run_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> (!issue_hold && !fetch_stop));

   a_r9_clk_on_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_stop |-> core_clk_en);
endmodule

bind core_wait_ctl core_wait_ctl_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wait_req    (wait_req),
   .irq         (irq),
   .dbg_irq     (dbg_irq),
   .issue_hold  (issue_hold),
   .fetch_stop  (fetch_stop),
   .waiting     (waiting),
   .wake        (wake),
   .core_clk_en (core_clk_en),
   .infl_cnt    (infl_cnt)
);

// File: tb/core_wait_ctl_tb.sv
module core_wait_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_vld = 0, retire_vld = 0, wait_req = 0, wait_long = 0;
   logic [AW-1:0] wait_pc = '0;
   logic          irq = 0, dbg_irq = 0, bus_other_active = 0;
   logic          issue_hold, fetch_stop, waiting, wake, core_clk_en;
   logic [AW-1:0] resume_pc;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_wait_ctl #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .retire_vld(retire_vld),
      .wait_req(wait_req), .wait_pc(wait_pc), .wait_long(wait_long),
      .irq(irq), .dbg_irq(dbg_irq), .bus_other_active(bus_other_active),
      .issue_hold(issue_hold), .fetch_stop(fetch_stop), .waiting(waiting),
      .wake(wake), .resume_pc(resume_pc), .core_clk_en(core_clk_en)
   );

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // advance one edge, then settle; inputs are changed after this, checks after #1
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic quiet();
      issue_vld = 0; retire_vld = 0; wait_req = 0; irq = 0; dbg_irq = 0;
   endtask

   task automatic t_reset();
      settle();
      chk("R1 issue_hold", issue_hold, 0);
      chk("R1 fetch_stop", fetch_stop, 0);
      chk("R1 waiting", waiting, 0);
      chk("R1 wake", wake, 0);
      chk("R1 core_clk_en", core_clk_en, 1);
   endtask

   task automatic t_drain_sleep_irq();
      issue_vld = 1; tick();            // count 1
      tick();                           // count 2
      issue_vld = 0; wait_req = 1; wait_pc = 32'h100; wait_long = 1;
      tick();                           // drain
      wait_req = 0; settle();
      chk("R2 hold after wait", issue_hold, 1);
      chk("R3 no stop while busy", fetch_stop, 0);
      issue_vld = 1; tick();            // ignored, count stays 2
      issue_vld = 0; retire_vld = 1; tick();  // count 1
      settle();
      chk("R3 waiting low with one in flight", waiting, 0);
      tick();                           // count 0 (R2: ignored issue not counted)
      retire_vld = 0; settle();
      chk("R3 still draining at count zero edge", fetch_stop, 0);
      tick();                           // sleep
      chk("R4 fetch_stop", fetch_stop, 1);
      chk("R4 waiting", waiting, 1);
      chk("R4 issue_hold", issue_hold, 1);
      bus_other_active = 0; settle();
      chk("R9 clk off, bus idle", core_clk_en, 0);
      bus_other_active = 1; settle();
      chk("R9 clk on, bus active", core_clk_en, 1);
      retire_vld = 1; wait_req = 1; issue_vld = 1; tick();
      quiet(); bus_other_active = 0; tick();
      chk("R5 still stopped", fetch_stop, 1);
      chk("R5 still waiting", waiting, 1);
      irq = 1; settle();
      chk("R6 waiting drops", waiting, 0);
      chk("R6 wake pulse", wake, 1);
      chk("R7 resume long", resume_pc, 32'h104);
      tick(); irq = 0; settle();
      chk("R6 hold released", issue_hold, 0);
      chk("R6 fetch resumed", fetch_stop, 0);
      chk("R6 wake ends", wake, 0);
      chk("R9 clk on in run", core_clk_en, 1);
   endtask

   task automatic t_dbg_short();
      wait_req = 1; wait_pc = 32'h2003; wait_long = 0; tick();
      wait_req = 0; tick();             // empty -> sleep
      chk("R4 sleep with nothing in flight", fetch_stop, 1);
      dbg_irq = 1; settle();
      chk("R10 dbg wake", wake, 1);
      chk("R10 waiting drops", waiting, 0);
      chk("R7 resume short aligned", resume_pc, 32'h2004);
      tick(); dbg_irq = 0; settle();
      chk("R10 back to run", issue_hold, 0);
   endtask

   task automatic t_pending();
      issue_vld = 1; tick();            // count 1
      issue_vld = 0; wait_req = 1; wait_pc = 32'h300; wait_long = 1; tick();
      wait_req = 0; bus_other_active = 0; irq = 1; settle();
      chk("R8 no wake while busy", wake, 0);
      chk("R9 clk on during drain", core_clk_en, 1);
      tick(); irq = 0;                  // pending latched
      retire_vld = 1; tick();           // count 0
      retire_vld = 0; settle();
      chk("R8 wake at drain end", wake, 1);
      chk("R8 no waiting", waiting, 0);
      chk("R8 no fetch stop", fetch_stop, 0);
      tick(); settle();
      chk("R8 running again", issue_hold, 0);
      chk("R8 never slept", fetch_stop, 0);
      chk("R7 resume after pending", resume_pc, 32'h304);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + 3);
      t_reset();
      rst_n = 1;
      tick();
      t_drain_sleep_irq();
      quiet(); tick();
      t_dbg_short();
      quiet(); tick();
      t_pending();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule